// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block is a real-time clock peripheral on a 32-bit register port in the system clock domain. It keeps a 47-bit tick counter that advances once for each pulse on a slow-tick enable input, at 32768 ticks per second. The upper 32 bits of the counter hold whole seconds. Software reads the counter as two words and loads it while counting is stopped. It programs a seconds alarm, and a match raises a sticky status flag that can drive an interrupt line.

Writes to the control word do not act at once. They are held until the next slow tick, which keeps the visible enable in step with the slow time base. Software sees the enable bit change only after that tick, so it polls control to learn when a start or stop has landed. A guard register accepts one initialisation word, which software uses to arm glitch detection.

Top module: `lp_rtc_top`

## Requirements
- R1: The seconds value is counter bits [46:15]. The alarm compares only these bits, so a counter one tick short of a whole second does not match.
- R2: Register offsets: control 0x04, status 0x18, counter upper word 0x1C, counter lower word 0x20, alarm 0x24, guard 0x30. Any other offset reads as zero.
- R3: In control, bit 0 is count enable, bit 1 is alarm enable and bit 3 is interrupt enable. All other control bits read as zero.
- R4: The counter can be loaded only while the control readback shows counting stopped. The lower word loads bits [31:0] and bits [14:0] of the upper word load bits [46:32]. Loads while counting are ignored, and the upper word reads back zero-extended.
- R5: A control write takes effect on the first slow tick after the write cycle. Before that tick, reads return the old value. If several writes arrive before a tick, the last one wins.
- R6: On each slow tick where count enable already reads 1, the counter adds one, with carry between the words, and wraps from 2^47-1 to 0. The tick that applies a new enable value counts according to the old value.
- R7: Status bit 0 is set one cycle after alarm enable is 1 and the seconds value equals the alarm register. It stays set after the match passes and is never set while alarm enable is 0.
- R8: Writing status with bit 0 = 1 clears the flag, unless a match is present in that cycle. Writing 0 has no effect.
- R9: The interrupt output is the status flag ANDed with alarm enable and interrupt enable.
- R10: Writing 0x41736166 to the guard register makes it read back that word. Any other write makes it read zero.
- R11: Reset clears the counter, control, pending control, status, alarm and guard registers to zero, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow-tick enable pulse, one system cycle wide |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench checks that control readback holds its old value until a tick, and that the last of two writes is the one applied. A design that applied writes at once, or kept the first write, fails here. It checks that the tick which starts counting does not count, and that the tick which stops counting does. An off-by-one in how the tick meets the enable shows up as a counter one step off. It checks carry from the lower word into the upper word and the wrap at 47 bits. It checks the alarm one tick before a whole second and at it, and that a clear is refused while a match is present. Writes of 0 to status, loads while running and disabled alarm or interrupt enables must leave the outputs unchanged.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_CNT_HI = 8'h1C;
  localparam logic [7:0] OFS_CNT_LO = 8'h20;
  localparam logic [7:0] OFS_ALARM  = 8'h24;
  localparam logic [7:0] OFS_GUARD  = 8'h30;

  localparam int unsigned BIT_CNT_EN   = 0;
  localparam int unsigned BIT_ALARM_EN = 1;
  localparam int unsigned BIT_IRQ_EN   = 3;
  localparam int unsigned BIT_FLAG     = 0;

  localparam logic [DATA_W-1:0] GUARD_WORD = 32'h4173_6166;

  typedef struct packed {
    logic irq_en;
    logic alarm_en;
    logic cnt_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_ctrl_sync.sv
module rtc_ctrl_sync
  import lp_rtc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  wr_i,
  input  ctrl_t wdata_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q, pend_q;
  logic  pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (tick_i && pend_vld_q) ctrl_q <= pend_q;
      // a write in a tick cycle waits for the following tick
      if (wr_i) begin
        pend_q     <= wdata_i;
        pend_vld_q <= 1'b1;
      end else if (tick_i) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W  = 47,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned HI_W = CNT_W - WORD_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end else begin
      if (ld_lo_i) cnt_q[WORD_W-1:0]     <= wdata_i;
      if (ld_hi_i) cnt_q[CNT_W-1:WORD_W] <= wdata_i[HI_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             wr_alarm_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic             clr_i,
  input  logic             alarm_en_i,
  input  logic             irq_en_i,
  output logic [SEC_W-1:0] alarm_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [SEC_W-1:0] alarm_q;
  logic             flag_q;
  logic             hit;

  assign hit = alarm_en_i && (sec_i == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_alarm_i) alarm_q <= wdata_i;
      // a live match overrides the clear
      flag_q <= (flag_q && !clr_i) || hit;
    end
  end

  assign alarm_o = alarm_q;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q && alarm_en_i && irq_en_i;
endmodule

// File: rtl/lp_rtc_top.sv
module lp_rtc_top
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_W   = 47,
  parameter int unsigned SUB_W   = 15,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned SEC_W = CNT_W - SUB_W;
  localparam int unsigned HI_W  = CNT_W - DATA_W;

  logic             wr;
  logic             wr_ctrl, wr_status, wr_hi, wr_lo, wr_alarm, wr_guard;
  ctrl_t            ctrl, ctrl_wd;
  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] alarm_val;
  logic             alarm_flag;
  logic [DATA_W-1:0] guard_q;

  assign wr        = req_i && we_i;
  assign wr_ctrl   = wr && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_status = wr && (addr_i == ADDR_W'(OFS_STATUS));
  assign wr_hi     = wr && (addr_i == ADDR_W'(OFS_CNT_HI));
  assign wr_lo     = wr && (addr_i == ADDR_W'(OFS_CNT_LO));
  assign wr_alarm  = wr && (addr_i == ADDR_W'(OFS_ALARM));
  assign wr_guard  = wr && (addr_i == ADDR_W'(OFS_GUARD));

  assign ctrl_wd.cnt_en   = wdata_i[BIT_CNT_EN];
  assign ctrl_wd.alarm_en = wdata_i[BIT_ALARM_EN];
  assign ctrl_wd.irq_en   = wdata_i[BIT_IRQ_EN];

  rtc_ctrl_sync u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wr_i   (wr_ctrl),
    .wdata_i(ctrl_wd),
    .ctrl_o (ctrl)
  );

  rtc_counter #(.CNT_W(CNT_W), .WORD_W(DATA_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (ctrl.cnt_en),
    .ld_lo_i(wr_lo),
    .ld_hi_i(wr_hi),
    .wdata_i(wdata_i),
    .cnt_o  (cnt)
  );

  rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_i     (cnt[CNT_W-1:SUB_W]),
    .wr_alarm_i(wr_alarm),
    .wdata_i   (wdata_i[SEC_W-1:0]),
    .clr_i     (wr_status && wdata_i[BIT_FLAG]),
    .alarm_en_i(ctrl.alarm_en),
    .irq_en_i  (ctrl.irq_en),
    .alarm_o   (alarm_val),
    .flag_o    (alarm_flag),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       guard_q <= '0;
    else if (wr_guard) guard_q <= (wdata_i == GUARD_WORD) ? GUARD_WORD : '0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_CTRL): begin
        rdata_o[BIT_CNT_EN]   = ctrl.cnt_en;
        rdata_o[BIT_ALARM_EN] = ctrl.alarm_en;
        rdata_o[BIT_IRQ_EN]   = ctrl.irq_en;
      end
      ADDR_W'(OFS_STATUS): rdata_o[BIT_FLAG] = alarm_flag;
      ADDR_W'(OFS_CNT_HI): rdata_o[HI_W-1:0] = cnt[CNT_W-1:DATA_W];
      ADDR_W'(OFS_CNT_LO): rdata_o = cnt[DATA_W-1:0];
      ADDR_W'(OFS_ALARM):  rdata_o[SEC_W-1:0] = alarm_val;
      ADDR_W'(OFS_GUARD):  rdata_o = guard_q;
      default:             rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lp_rtc_chk.sv
module lp_rtc_chk
  import lp_rtc_pkg::*;
#(
  parameter int unsigned CNT_W  = 47,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input ctrl_t             ctrl_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              flag_i
);
  // R5
  ctrl_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ctrl_i));

  // R6
  cnt_steps_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctrl_i.cnt_en) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  // R4
  cnt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(req_i && we_i)) |=> $stable(cnt_i));

  // R7
  flag_needs_alarm_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(ctrl_i.alarm_en));

  // R8
  flag_falls_on_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(req_i && we_i && addr_i == ADDR_W'(OFS_STATUS) && wdata_i[BIT_FLAG]));

  // R9
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($rose(flag_i) || $past(tick_i)));
endmodule

bind lp_rtc_top lp_rtc_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .ctrl_i (ctrl),
  .cnt_i  (cnt),
  .flag_i (alarm_flag)
);

// File: tb/sim_lp_rtc_top.sv
module sim_lp_rtc_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h18, A_HI = 8'h1C,
                         A_LO = 8'h20, A_ALM = 8'h24, A_GRD = 8'h30;

  // {lower word, upper word written}
  localparam logic [63:0] LOAD_VEC [4] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'hDEAD_BEEF, 32'h0000_1234},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h0001_8000, 32'h0000_7FFF}
  };

  lp_rtc_top u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    // R11 reset state
    rdchk("R11 ctrl", A_CTRL, 0);
    rdchk("R11 status", A_STAT, 0);
    rdchk("R11 lo", A_LO, 0);
    rdchk("R11 hi", A_HI, 0);
    chk("R11 irq", {31'b0, irq_o}, 0);

    // R4 load table, counting stopped
    foreach (LOAD_VEC[i]) begin
      wr(A_LO, LOAD_VEC[i][63:32]);
      wr(A_HI, LOAD_VEC[i][31:0]);
      rdchk("R4 lo load", A_LO, LOAD_VEC[i][63:32]);
      rdchk("R4 hi load", A_HI, {17'b0, LOAD_VEC[i][14:0]});
    end

    // R5 deferred control, last write wins
    wr(A_LO, 32'h10); wr(A_HI, 0);
    wr(A_CTRL, 32'h8);
    wr(A_CTRL, 32'h1);
    rdchk("R5 old value before tick", A_CTRL, 0);
    tick();
    rdchk("R5 applied at tick", A_CTRL, 32'h1);
    // R6 enabling tick does not count
    rdchk("R6 enable tick", A_LO, 32'h10);
    tick(); tick(); tick();
    rdchk("R6 three ticks", A_LO, 32'h13);
    // R4 load ignored while counting
    wr(A_LO, 32'h5555);
    rdchk("R4 load while running", A_LO, 32'h13);
    // R6 stopping tick still counts
    wr(A_CTRL, 0);
    rdchk("R5 still running", A_CTRL, 32'h1);
    tick();
    rdchk("R5 stop applied", A_CTRL, 0);
    rdchk("R6 stopping tick counts", A_LO, 32'h14);
    tick();
    rdchk("R6 no count while stopped", A_LO, 32'h14);

    // R6 carry into upper word
    wr(A_LO, 32'hFFFF_FFFF); wr(A_HI, 3);
    wr(A_CTRL, 1); tick(); tick();
    rdchk("R6 carry lo", A_LO, 0);
    rdchk("R6 carry hi", A_HI, 4);
    // R6 wrap at 47 bits
    wr(A_CTRL, 0); tick();
    wr(A_LO, 32'hFFFF_FFFF); wr(A_HI, 32'h7FFF);
    wr(A_CTRL, 1); tick(); tick();
    rdchk("R6 wrap lo", A_LO, 0);
    rdchk("R6 wrap hi", A_HI, 0);

    // R1 / R7 alarm at whole second 5
    wr(A_CTRL, 0); tick();
    wr(A_LO, 32'h0002_7FFF); wr(A_HI, 0);
    wr(A_ALM, 5);
    rdchk("R2 alarm offset", A_ALM, 5);
    wr(A_CTRL, 32'hB); tick(); idle();
    rdchk("R1 one tick short of second", A_STAT, 0);
    chk("R9 irq low before match", {31'b0, irq_o}, 0);
    tick(); idle();
    rdchk("R7 flag on match", A_STAT, 1);
    chk("R9 irq on match", {31'b0, irq_o}, 1);
    wr(A_ALM, 100); tick(); idle();
    rdchk("R7 flag sticky", A_STAT, 1);
    // R8 write-one-to-clear
    wr(A_STAT, 0); idle();
    rdchk("R8 write zero no effect", A_STAT, 1);
    wr(A_STAT, 1);
    rdchk("R8 write one clears", A_STAT, 0);
    chk("R8 irq cleared", {31'b0, irq_o}, 0);
    wr(A_ALM, 5); idle();
    rdchk("R7 flag re-set", A_STAT, 1);
    wr(A_STAT, 1); idle();
    rdchk("R8 clear refused during match", A_STAT, 1);
    // R9 gating by interrupt enable
    wr(A_CTRL, 32'h3); tick(); idle();
    chk("R9 irq gated by irq enable", {31'b0, irq_o}, 0);
    rdchk("R9 flag kept", A_STAT, 1);
    wr(A_CTRL, 32'hB); tick(); idle();
    chk("R9 irq back", {31'b0, irq_o}, 1);
    // R7 alarm disabled never sets
    wr(A_ALM, 100); wr(A_STAT, 1);
    wr(A_CTRL, 32'h1); tick();
    wr(A_ALM, 5); idle(); idle();
    rdchk("R7 no flag when alarm off", A_STAT, 0);

    // R3 reserved control bits
    wr(A_CTRL, 32'hFFFF_FFFF); tick();
    rdchk("R3 control bits", A_CTRL, 32'hB);

    // R10 guard
    wr(A_GRD, 32'h4173_6166);
    rdchk("R10 guard accepted", A_GRD, 32'h4173_6166);
    wr(A_GRD, 32'h1234_5678);
    rdchk("R10 guard rejected", A_GRD, 0);

    // R2 unmapped offsets
    rdchk("R2 unmapped 00", 8'h00, 0);
    rdchk("R2 unmapped 08", 8'h08, 0);
    rdchk("R2 unmapped 2C", 8'h2C, 0);
    rdchk("R2 unmapped 34", 8'h34, 0);

    // R11 reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rdchk("R11 ctrl after reset", A_CTRL, 0);
    rdchk("R11 lo after reset", A_LO, 0);
    rdchk("R11 status after reset", A_STAT, 0);
    rdchk("R11 alarm after reset", A_ALM, 0);
    chk("R11 irq after reset", {31'b0, irq_o}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule